// File: doc/BRIEF.md
# Flash Program/Erase Engine with Status Polling

This block carries out word programs and region erases that a command decoder has already accepted. It works against a behavioural word array. The time each operation keeps the array busy is modelled with cycle counters. A sector erase or a block erase can be paused, and can later continue with the time it still has left. While an operation runs, or while an erase is paused, a read does not return the stored word. It returns a status word instead. Software polls that status word to tell a program in progress, an erase in progress and a paused erase region apart.

A request is one cycle of `req_valid_i`, carrying an operation code, an address and a data word. A read is one cycle of `rd_i` with an address. The result appears on `rd_data_o` in the following cycle and stays there until the next read. `busy_o` shows that an internal operation is running. `susp_o` shows that an erase is paused.

The defaults use a small array of 1024 words, with 32-word sectors and 256-word blocks, so that it elaborates quickly. A full-size part sets the address width to 20, the sector width to 11 and the block width to 15.

Top module: `pe_engine`

## Requirements
- R1: After reset, `busy_o`=0, `susp_o`=0 and `rd_data_o`=0000h. Every array word reads FFFFh.
- R2: A program request (op 0) accepted while idle holds `busy_o` high for exactly T_PROG cycles. The word then holds its old contents ANDed with the request data.
- R3: While a program runs, a read returns a status word: bit 7 is the inverse of bit 7 of the data being written, bit 6 inverts on each successive read, bit 2 holds its value, and all other bits are 0.
- R4: Op 1 erases the sector whose address bits above SECT_W match the request address. Op 2 erases the block whose address bits above BLK_W match. Op 3 erases every word. When the erase ends, the erased words read FFFFh and all other words are unchanged.
- R5: While an erase runs, a read returns bit 7 = 0, and bits 6 and 2 each invert on each successive read. All other bits are 0.
- R6: A suspend request (op 4) during a sector or block erase keeps `busy_o` high and raises `susp_o` exactly T_SUSP cycles later. At that point `busy_o` falls.
- R7: While an erase is paused, a read inside the paused region returns bits 7 and 6 set, with bit 2 inverting on each such read. A read outside the region returns array data.
- R8: While an erase is paused, a program outside the paused region runs and reports program status, with `susp_o` held high. A program that targets the paused region is dropped and does not raise `busy_o`.
- R9: A resume request (op 5) while paused lowers `susp_o` and raises `busy_o`. The erase then ends after exactly the cycles it had left when the suspend request was taken.
- R10: Requests that arrive while busy are ignored, except a suspend during a sector or block erase. A suspend during a chip erase is ignored. A resume while idle is ignored.
- R11: `rd_data_o` updates only on the edge that samples `rd_i` high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle |
| req_op_i | input | 3 | Operation: 0 program, 1 sector erase, 2 block erase, 3 chip erase, 4 suspend, 5 resume |
| req_addr_i | input | ADDR_W | Word address or region address |
| req_data_i | input | 16 | Program data |
| rd_i | input | 1 | Read strobe, one per access |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 16 | Array word or status word |
| busy_o | output | 1 | Internal operation running |
| susp_o | output | 1 | Erase paused |

## Verification
A read result is due on the cycle after its strobe edge. A monitor pops the expected word from the scoreboard at the falling edge after that edge, so the comparison never races the update. The program and erase end edges are counted from the request edge: T_PROG cycles for a program, T_SUSP cycles for a suspend, and T_SE minus the cycles already run for a resumed erase. `busy_o` and `susp_o` are sampled one falling edge before and one falling edge after each due edge. Status polls are placed well inside the busy window, so that no read coincides with a completion edge.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int DW = 16;

  typedef enum logic [2:0] {
    OP_PROG    = 3'd0,
    OP_SERASE  = 3'd1,
    OP_BERASE  = 3'd2,
    OP_CERASE  = 3'd3,
    OP_SUSPEND = 3'd4,
    OP_RESUME  = 3'd5
  } op_e;

  typedef enum logic [1:0] {EK_SECT, EK_BLK, EK_CHIP} ekind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_ERASE, ST_SWAIT, ST_SUSP, ST_SPROG
  } state_e;

  typedef enum logic [1:0] {RM_ARRAY, RM_PROG, RM_ERASE, RM_SHIT} rmode_e;
endpackage

// File: rtl/pe_timer.sv
module pe_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          run_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CW'(1));
endmodule

// File: rtl/pe_region.sv
module pe_region
  import pe_pkg::*;
#(
  parameter int AW = 10,
  parameter int SW = 5,
  parameter int BW = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  ekind_e        kind_i,
  output logic          hit_o
);
  always_comb begin
    case (kind_i)
      EK_SECT: hit_o = (addr_i >> SW) == (base_i >> SW);
      EK_BLK:  hit_o = (addr_i >> BW) == (base_i >> BW);
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pe_array.sv
module pe_array
  import pe_pkg::*;
#(
  parameter int AW = 10,
  parameter int SW = 5,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [DW-1:0] prog_data_i,
  input  logic          erase_i,
  input  logic [AW-1:0] erase_base_i,
  input  ekind_e        erase_kind_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_word_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_kind_i == EK_CHIP ||
            (erase_kind_i == EK_SECT && (AW'(i) >> SW) == (erase_base_i >> SW)) ||
            (erase_kind_i == EK_BLK  && (AW'(i) >> BW) == (erase_base_i >> BW)))
          mem_q[i] <= '1;
      end
    end else if (prog_i) begin
      // cells only move toward 0
      mem_q[prog_addr_i] <= mem_q[prog_addr_i] & prog_data_i;
    end
  end

  assign rd_word_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pe_status.sv
module pe_status
  import pe_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  rmode_e        mode_i,
  input  logic          pbit_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] data_o
);
  logic t6_q, t2_q;
  logic [DW-1:0] st;

  always_comb begin
    st = '0;
    case (mode_i)
      RM_PROG:  begin st[7] = ~pbit_i; st[6] = t6_q; st[2] = t2_q; end
      RM_ERASE: begin st[6] = t6_q;    st[2] = t2_q; end
      RM_SHIT:  begin st[7] = 1'b1;    st[6] = 1'b1; st[2] = t2_q; end
      default:  st = word_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      t6_q   <= 1'b0;
      t2_q   <= 1'b0;
    end else if (rd_i) begin
      data_o <= st;
      if (mode_i == RM_PROG || mode_i == RM_ERASE) t6_q <= ~t6_q;
      if (mode_i == RM_ERASE || mode_i == RM_SHIT) t2_q <= ~t2_q;
    end
  end
endmodule

// File: rtl/pe_engine.sv
module pe_engine
  import pe_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SECT_W = 5,
  parameter int BLK_W  = 8,
  parameter int T_PROG = 8,
  parameter int T_SE   = 40,
  parameter int T_CE   = 30,
  parameter int T_SUSP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_data_o,
  output logic              busy_o,
  output logic              susp_o
);
  localparam int TM1  = (T_PROG > T_SE) ? T_PROG : T_SE;
  localparam int TM2  = (T_CE > T_SUSP) ? T_CE : T_SUSP;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);

  state_e state_q, state_d;
  ekind_e ekind_q;
  logic [ADDR_W-1:0] ebase_q, paddr_q;
  logic [DW-1:0]     pdata_q, arr_word;
  logic p_load, e_load, s_load, p_exp, e_exp, s_exp;
  logic latch_p, latch_e, do_prog, do_erase;
  logic prog_hit, rd_hit;
  logic [CW-1:0] e_val;
  rmode_e rmode;
  op_e    op;

  assign op    = op_e'(req_op_i);
  assign e_val = (op == OP_CERASE) ? CW'(T_CE) : CW'(T_SE);

  pe_timer #(.CW(CW)) u_ptmr (
    .clk_i, .rst_ni, .load_i(p_load), .val_i(CW'(T_PROG)),
    .run_i(state_q == ST_PROG || state_q == ST_SPROG), .expire_o(p_exp));
  pe_timer #(.CW(CW)) u_etmr (
    .clk_i, .rst_ni, .load_i(e_load), .val_i(e_val),
    .run_i(state_q == ST_ERASE), .expire_o(e_exp));
  pe_timer #(.CW(CW)) u_stmr (
    .clk_i, .rst_ni, .load_i(s_load), .val_i(CW'(T_SUSP)),
    .run_i(state_q == ST_SWAIT), .expire_o(s_exp));

  pe_region #(.AW(ADDR_W), .SW(SECT_W), .BW(BLK_W)) u_preg (
    .addr_i(req_addr_i), .base_i(ebase_q), .kind_i(ekind_q), .hit_o(prog_hit));
  pe_region #(.AW(ADDR_W), .SW(SECT_W), .BW(BLK_W)) u_rreg (
    .addr_i(rd_addr_i), .base_i(ebase_q), .kind_i(ekind_q), .hit_o(rd_hit));

  always_comb begin
    state_d = state_q;
    p_load = 1'b0; e_load = 1'b0; s_load = 1'b0;
    latch_p = 1'b0; latch_e = 1'b0; do_prog = 1'b0; do_erase = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        case (op)
          OP_PROG: begin p_load = 1'b1; latch_p = 1'b1; state_d = ST_PROG; end
          OP_SERASE, OP_BERASE, OP_CERASE: begin
            e_load = 1'b1; latch_e = 1'b1; state_d = ST_ERASE;
          end
          default: ;
        endcase
      end
      ST_PROG: if (p_exp) begin do_prog = 1'b1; state_d = ST_IDLE; end
      ST_ERASE: begin
        if (e_exp) begin
          do_erase = 1'b1; state_d = ST_IDLE;
        end else if (req_valid_i && op == OP_SUSPEND && ekind_q != EK_CHIP) begin
          s_load = 1'b1; state_d = ST_SWAIT;
        end
      end
      ST_SWAIT: if (s_exp) state_d = ST_SUSP;
      ST_SUSP: if (req_valid_i) begin
        if (op == OP_RESUME) state_d = ST_ERASE;
        else if (op == OP_PROG && !prog_hit) begin
          p_load = 1'b1; latch_p = 1'b1; state_d = ST_SPROG;
        end
      end
      ST_SPROG: if (p_exp) begin do_prog = 1'b1; state_d = ST_SUSP; end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ekind_q <= EK_SECT;
      ebase_q <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (latch_p) begin
        paddr_q <= req_addr_i;
        pdata_q <= req_data_i;
      end
      if (latch_e) begin
        ebase_q <= req_addr_i;
        ekind_q <= (op == OP_SERASE) ? EK_SECT : (op == OP_BERASE) ? EK_BLK : EK_CHIP;
      end
    end
  end

  pe_array #(.AW(ADDR_W), .SW(SECT_W), .BW(BLK_W)) u_array (
    .clk_i, .rst_ni,
    .prog_i(do_prog), .prog_addr_i(paddr_q), .prog_data_i(pdata_q),
    .erase_i(do_erase), .erase_base_i(ebase_q), .erase_kind_i(ekind_q),
    .rd_addr_i, .rd_word_o(arr_word));

  always_comb begin
    case (state_q)
      ST_PROG, ST_SPROG:  rmode = RM_PROG;
      ST_ERASE, ST_SWAIT: rmode = RM_ERASE;
      ST_SUSP:            rmode = rd_hit ? RM_SHIT : RM_ARRAY;
      default:            rmode = RM_ARRAY;
    endcase
  end

  pe_status u_status (
    .clk_i, .rst_ni, .rd_i, .mode_i(rmode), .pbit_i(pdata_q[7]),
    .word_i(arr_word), .data_o(rd_data_o));

  assign busy_o = (state_q == ST_PROG) || (state_q == ST_ERASE) ||
                  (state_q == ST_SWAIT) || (state_q == ST_SPROG);
  assign susp_o = (state_q == ST_SUSP) || (state_q == ST_SPROG);
endmodule

// File: rtl/pe_engine_chk.sv
module pe_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [2:0]  req_op_i,
  input logic        rd_i,
  input logic [15:0] rd_data_o,
  input logic        busy_o,
  input logic        susp_o
);
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !susp_o) |-> $past(req_valid_i)); // R2
  AST_SUSP_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_o) |-> $past(busy_o)); // R6
  AST_RESUME_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(susp_o) |-> busy_o); // R9
  AST_SUSP_PROG_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_o && $past(susp_o) && $rose(busy_o)) |->
      $past(req_valid_i && req_op_i == 3'd0)); // R8
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o)); // R11
endmodule

bind pe_engine pe_engine_chk u_chk (.*);

// File: tb/tb_pe_engine.sv
module tb_pe_engine;
  import pe_pkg::*;

  localparam int TP = 8, TSE = 40, TCE = 30, TSU = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, rd = 1'b0;
  logic [2:0]  req_op = '0;
  logic [9:0]  req_addr = '0, rd_addr = '0;
  logic [15:0] req_data = '0;
  logic [15:0] rd_data;
  logic        busy, susp;

  pe_engine #(.ADDR_W(10), .SECT_W(5), .BLK_W(8), .T_PROG(TP), .T_SE(TSE),
              .T_CE(TCE), .T_SUSP(TSU)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .rd_i(rd), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .susp_o(susp));

  int n_chk = 0, n_err = 0;
  logic t6 = 1'b0, t2 = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk)
    if (rd_seen && exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());

  task automatic read(logic [9:0] a, logic [15:0] e, string tag);
    @(negedge clk); rd = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic read_prog(logic [9:0] a, logic d7, string tag);
    read(a, {8'h00, ~d7, t6, 3'b000, t2, 2'b00}, tag); t6 = ~t6;
  endtask
  task automatic read_erase(logic [9:0] a, string tag);
    read(a, {8'h00, 1'b0, t6, 3'b000, t2, 2'b00}, tag); t6 = ~t6; t2 = ~t2;
  endtask
  task automatic read_susp(logic [9:0] a, string tag);
    read(a, {8'h00, 1'b1, 1'b1, 3'b000, t2, 2'b00}, tag); t2 = ~t2;
  endtask

  task automatic req(op_e o, logic [9:0] a, logic [15:0] d);
    @(negedge clk); req_valid = 1'b1; req_op = o; req_addr = a; req_data = d;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    check(tag, 16'(busy), 16'h0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 16'(busy), 16'h0);
    check("R1 susp", 16'(susp), 16'h0);
    check("R1 rd_data", rd_data, 16'h0000);
    rst_n = 1'b1;
    read(10'h005, 16'hFFFF, "R1 erased at reset");

    // R2 program timing and AND rule
    req(OP_PROG, 10'h005, 16'h1234);
    repeat (TP - 1) @(negedge clk);
    check("R2 busy before end", 16'(busy), 16'h1);
    @(negedge clk);
    check("R2 busy after end", 16'(busy), 16'h0);
    read(10'h005, 16'h1234, "R2 programmed");
    req(OP_PROG, 10'h005, 16'hFF0F);
    wait_idle("R2 idle");
    read(10'h005, 16'h1204, "R2 and rule");

    // R3 program status
    req(OP_PROG, 10'h040, 16'h00A5);
    read_prog(10'h040, 1'b1, "R3 poll 1");
    read_prog(10'h040, 1'b1, "R3 poll 2");
    read_prog(10'h040, 1'b1, "R3 poll 3");
    wait_idle("R3 idle");
    read(10'h040, 16'h00A5, "R3 true data");

    // R4/R5 sector erase
    req(OP_PROG, 10'h05F, 16'h0000); wait_idle("R4 idle");
    req(OP_PROG, 10'h060, 16'h0000); wait_idle("R4 idle");
    req(OP_SERASE, 10'h045, 16'h0);
    read_erase(10'h045, "R5 poll 1");
    read_erase(10'h045, "R5 poll 2");
    read_erase(10'h045, "R5 poll 3");
    wait_idle("R4 sector done");
    read(10'h040, 16'hFFFF, "R4 sector low");
    read(10'h05F, 16'hFFFF, "R4 sector high");
    read(10'h060, 16'h0000, "R4 next sector kept");
    read(10'h005, 16'h1204, "R4 other kept");

    // R6/R7 block erase with suspend
    req(OP_PROG, 10'h120, 16'h5555); wait_idle("R6 idle");
    req(OP_PROG, 10'h210, 16'h0F0F); wait_idle("R6 idle");
    req(OP_BERASE, 10'h150, 16'h0);
    repeat (3) @(negedge clk);
    req(OP_SUSPEND, 10'h0, 16'h0);   // taken 5 cycles into the erase
    repeat (TSU - 1) @(negedge clk);
    check("R6 susp before latency", 16'(susp), 16'h0);
    check("R6 busy during latency", 16'(busy), 16'h1);
    @(negedge clk);
    check("R6 susp after latency", 16'(susp), 16'h1);
    check("R6 busy released", 16'(busy), 16'h0);
    read_susp(10'h100, "R7 region poll 1");
    read_susp(10'h1FF, "R7 region poll 2");
    read(10'h210, 16'h0F0F, "R7 outside region");
    read(10'h005, 16'h1204, "R7 outside region");

    // R8 program during suspend
    req(OP_PROG, 10'h1A0, 16'h0000);
    check("R8 inside dropped", 16'(busy), 16'h0);
    req(OP_PROG, 10'h300, 16'h0080);
    check("R8 outside busy", 16'(busy), 16'h1);
    check("R8 still suspended", 16'(susp), 16'h1);
    read_prog(10'h300, 1'b1, "R8 program status");
    wait_idle("R8 idle");
    check("R8 suspended after", 16'(susp), 16'h1);
    read(10'h300, 16'h0080, "R8 programmed");

    // R9 resume with remaining time
    req(OP_RESUME, 10'h0, 16'h0);
    check("R9 susp low", 16'(susp), 16'h0);
    check("R9 busy high", 16'(busy), 16'h1);
    repeat (TSE - 5 - 1) @(negedge clk);
    check("R9 busy before remainder", 16'(busy), 16'h1);
    @(negedge clk);
    check("R9 done at remainder", 16'(busy), 16'h0);
    read(10'h120, 16'hFFFF, "R9 block erased");
    read(10'h210, 16'h0F0F, "R9 other block kept");
    read(10'h300, 16'h0080, "R9 suspend program kept");

    // R10 ignored requests
    req(OP_PROG, 10'h007, 16'h00F0);
    req(OP_PROG, 10'h008, 16'h0000);
    wait_idle("R10 idle");
    read(10'h008, 16'hFFFF, "R10 busy program ignored");
    read(10'h007, 16'h00F0, "R10 first program");
    repeat (2) @(negedge clk);
    check("R11 data holds", rd_data, 16'h00F0);
    req(OP_RESUME, 10'h0, 16'h0);
    check("R10 resume in idle", 16'({busy, susp}), 16'h0);
    req(OP_CERASE, 10'h0, 16'h0);
    req(OP_SUSPEND, 10'h0, 16'h0);
    repeat (TSU + 1) @(negedge clk);
    check("R10 chip suspend ignored", 16'(susp), 16'h0);
    check("R10 chip still busy", 16'(busy), 16'h1);
    wait_idle("R4 chip done");
    read(10'h300, 16'hFFFF, "R4 chip erase");
    read(10'h005, 16'hFFFF, "R4 chip erase");
    read(10'h060, 16'hFFFF, "R4 chip erase");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule